// File: doc/BRIEF.md
# NFC polling loop phase scheduler

This block sequences a contactless front end through its polling loop. Each loop cycle visits up to seven phases in a fixed order: four reader-detection phases (type A, type B, type F at 212 kbit/s, type F at 424 kbit/s), a peer-to-peer initiator response wait, a card-emulation window and a pause window. Every phase has its own enable, and the phases that are disabled are skipped without spending any cycle. The radio logic follows a one-hot phase-select output.

Each reader phase lasts a fixed number of time ticks that depends on its technology. The emulation window and the pause window are programmed in a coarse unit of about 48 µs. The initiator wait is programmed in 1 ms units. A prescaler divides the system clock into ticks, and each phase restarts that prescaler so that phase lengths are exact. The loop starts only on a host start pulse, and only if at least one reader technology is enabled. A detection during a reader or initiator phase stops the loop and records which phase saw the detection. Configuration writes go into a shadow copy. The running loop takes that copy in only when a full cycle ends.

Top module: `nfc_poll_sched`

## Requirements
- R1: After reset, phase_sel is 0, busy is 0, detected is 0 and det_tech is 0.
- R2: Phases run in this order, each with its phase_sel bit: A (bit 0), B (bit 1), F212 (bit 2), F424 (bit 3), initiator wait (bit 4), emulation (bit 5), pause (bit 6). A disabled phase takes zero cycles. After the last enabled phase, the first enabled phase of the next cycle follows on the next clock.
- R3: The reader phases A, B, F212 and F424 hold for DUR_A, DUR_B, DUR_F212 and DUR_F424 ticks. One tick is TICK_DIV clock cycles, so the defaults give 12, 16, 20 and 24 cycles.
- R4: The emulation phase lasts cfg_emu_len×PAUSE_UNIT ticks and the pause phase lasts cfg_pause_len×PAUSE_UNIT ticks. A length of 0 skips the phase even when its enable is set.
- R5: When enabled, the initiator wait comes right after the F424 slot and lasts cfg_p2p_tmo×MS_UNIT ticks. A timeout of 0 skips it.
- R6: A host_start pulse starts the loop only when at least one bit of cfg_rd_en is set. With emulation only, pause only, or no enable at all, host_start leaves busy at 0 and phase_sel at 0.
- R7: When detect is high on a clock edge during a phase with bits 0 to 4, the loop stops. From the next cycle, phase_sel is 0 and busy is 0, detected is 1, and det_tech holds the bit index of that phase (0 to 4). These values hold until the next host_start.
- R8: detect is ignored during the emulation and pause phases, and the phase runs to its full length.
- R9: Only host_start restarts a stopped loop. host_start while busy is ignored. host_start while stopped clears detected.
- R10: A configuration write (cfg_we) while the loop runs takes effect at the start of the next full loop cycle, and the current cycle completes with the old settings. The loop repeats until a detection.
- R11: At most one bit of phase_sel is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes all cfg_* inputs into the shadow configuration |
| cfg_rd_en | input | 4 | Reader enables: bit0 A, bit1 B, bit2 F212, bit3 F424 |
| cfg_p2p_en | input | 1 | Initiator wait enable |
| cfg_p2p_tmo | input | TMO_W | Initiator response timeout in ms units |
| cfg_emu_en | input | 1 | Emulation window enable |
| cfg_emu_len | input | LEN_W | Emulation window length in pause units |
| cfg_pause_en | input | 1 | Pause window enable |
| cfg_pause_len | input | LEN_W | Pause window length in pause units |
| host_start | input | 1 | Host request to start the polling loop |
| detect | input | 1 | Detection indication from the radio logic |
| phase_sel | output | 7 | One-hot active phase, 0 when idle |
| busy | output | 1 | Loop running |
| detected | output | 1 | Loop stopped on a detection |
| det_tech | output | 3 | Index of the phase that saw the detection |

## Verification
The embedded properties check on every cycle that phase_sel is never more than one-hot and that a detection in a reader or initiator phase stops the loop on the next edge. They also check that detect in the emulation or pause window never sets detected, that only host_start leaves the stopped state, and that the recorded technology holds steady. Phase lengths, skip order, zero-length skips, the configuration hand-over at a cycle boundary, and the degenerate emulation-only and pause-only modes are shown only by the bench scenarios. The bench scoreboard compares every phase segment against its expected value and length.

// File: rtl/nfc_poll_sched.sv
module nfc_poll_sched #(
  parameter int TICK_DIV   = 4,
  parameter int DUR_A      = 3,
  parameter int DUR_B      = 4,
  parameter int DUR_F212   = 5,
  parameter int DUR_F424   = 6,
  parameter int PAUSE_UNIT = 2,
  parameter int MS_UNIT    = 3,
  parameter int LEN_W      = 16,
  parameter int TMO_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_rd_en,
  input  logic             cfg_p2p_en,
  input  logic [TMO_W-1:0] cfg_p2p_tmo,
  input  logic             cfg_emu_en,
  input  logic [LEN_W-1:0] cfg_emu_len,
  input  logic             cfg_pause_en,
  input  logic [LEN_W-1:0] cfg_pause_len,
  input  logic             host_start,
  input  logic             detect,
  output logic [6:0]       phase_sel,
  output logic             busy,
  output logic             detected,
  output logic [2:0]       det_tech
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [3:0]       sh_rd, ac_rd;
  logic             sh_p2p, ac_p2p, sh_emu, ac_emu, sh_pau, ac_pau;
  logic [TMO_W-1:0] sh_tmo, ac_tmo;
  logic [LEN_W-1:0] sh_elen, ac_elen, sh_plen, ac_plen;
  logic [2:0]       cur;
  logic [PW-1:0]    pre;
  logic [31:0]      units, cur_len;
  logic [6:0]       sh_en, ac_en;
  logic [3:0]       nxt_same, wrap_first;
  logic             tick, phase_end, in_reader;

  function automatic logic [3:0] first_from(input logic [6:0] en, input logic [3:0] from);
    first_from = 4'd7;
    for (int i = 6; i >= 0; i--)
      if (en[i] && i >= int'(from)) first_from = 4'(i);
  endfunction

  assign sh_en = {sh_pau && sh_plen != 0, sh_emu && sh_elen != 0, sh_p2p && sh_tmo != 0, sh_rd};
  assign ac_en = {ac_pau && ac_plen != 0, ac_emu && ac_elen != 0, ac_p2p && ac_tmo != 0, ac_rd};
  assign nxt_same   = first_from(ac_en, {1'b0, cur} + 4'd1);
  assign wrap_first = first_from(sh_en, 4'd0);

  always_comb begin
    case (cur)
      3'd0:    cur_len = 32'(DUR_A);
      3'd1:    cur_len = 32'(DUR_B);
      3'd2:    cur_len = 32'(DUR_F212);
      3'd3:    cur_len = 32'(DUR_F424);
      3'd4:    cur_len = 32'(ac_tmo) * 32'(MS_UNIT);
      3'd5:    cur_len = 32'(ac_elen) * 32'(PAUSE_UNIT);
      default: cur_len = 32'(ac_plen) * 32'(PAUSE_UNIT);
    endcase
  end

  assign tick      = (pre == PW'(TICK_DIV - 1));
  assign phase_end = busy && tick && (units == cur_len - 32'd1);
  assign in_reader = (cur <= 3'd4);
  assign phase_sel = busy ? (7'd1 << cur) : 7'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sh_rd, sh_p2p, sh_tmo, sh_emu, sh_elen, sh_pau, sh_plen} <= '0;
      {ac_rd, ac_p2p, ac_tmo, ac_emu, ac_elen, ac_pau, ac_plen} <= '0;
      cur <= '0; pre <= '0; units <= '0;
      busy <= 1'b0; detected <= 1'b0; det_tech <= '0;
    end else begin
      if (cfg_we) begin
        sh_rd <= cfg_rd_en; sh_p2p <= cfg_p2p_en; sh_tmo <= cfg_p2p_tmo;
        sh_emu <= cfg_emu_en; sh_elen <= cfg_emu_len;
        sh_pau <= cfg_pause_en; sh_plen <= cfg_pause_len;
      end
      if (!busy) begin
        if (host_start) begin
          detected <= 1'b0;
          if (|sh_rd) begin
            busy <= 1'b1;
            cur <= wrap_first[2:0];
            pre <= '0; units <= '0;
            ac_rd <= sh_rd; ac_p2p <= sh_p2p; ac_tmo <= sh_tmo;
            ac_emu <= sh_emu; ac_elen <= sh_elen; ac_pau <= sh_pau; ac_plen <= sh_plen;
          end
        end
      end else if (detect && in_reader) begin
        busy <= 1'b0;
        detected <= 1'b1;
        det_tech <= cur;
      end else if (phase_end) begin
        pre <= '0; units <= '0;
        if (nxt_same != 4'd7) cur <= nxt_same[2:0];
        else begin
          ac_rd <= sh_rd; ac_p2p <= sh_p2p; ac_tmo <= sh_tmo;
          ac_emu <= sh_emu; ac_elen <= sh_elen; ac_pau <= sh_pau; ac_plen <= sh_plen;
          if (|sh_rd) cur <= wrap_first[2:0];
          else busy <= 1'b0;
        end
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) units <= units + 32'd1;
      end
    end
  end

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(phase_sel));

  a_r7_stop_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
    busy && detect && (phase_sel[4:0] != 5'd0) |=> !busy && detected && phase_sel == 7'd0);

  a_r8_window_ignores_detect: assert property (@(posedge clk) disable iff (!rst_n)
    busy && detect && (phase_sel[6:5] != 2'd0) |=> !detected);

  a_r9_restart_only_on_host: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !host_start |=> !busy);

  a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    detected && !busy && !host_start |=> detected && $stable(det_tech));

  a_r6_needs_reader: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && host_start && sh_rd == 4'd0 |=> !busy && phase_sel == 7'd0);
endmodule

// File: tb/nfc_poll_sched_tb.sv
module nfc_poll_sched_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_p2p_en = 0, cfg_emu_en = 0, cfg_pause_en = 0;
  logic [3:0] cfg_rd_en = 0;
  logic [7:0] cfg_p2p_tmo = 0;
  logic [15:0] cfg_emu_len = 0, cfg_pause_len = 0;
  logic host_start = 0, detect = 0;
  logic [6:0] phase_sel;
  logic busy, detected;
  logic [2:0] det_tech;

  localparam logic [6:0] PA = 7'h01, PB = 7'h02, PF2 = 7'h04, PF4 = 7'h08,
                         PP2 = 7'h10, PEM = 7'h20, PPA = 7'h40;

  int total = 0, bad = 0;
  int exp_v[$], exp_l[$];
  string exp_t[$];

  always #2 clk = ~clk;

  nfc_poll_sched dut_i (.clk, .rst_n, .cfg_we, .cfg_rd_en, .cfg_p2p_en, .cfg_p2p_tmo,
    .cfg_emu_en, .cfg_emu_len, .cfg_pause_en, .cfg_pause_len, .host_start, .detect,
    .phase_sel, .busy, .detected, .det_tech);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] v, input int l, input string t);
    exp_v.push_back(int'(v)); exp_l.push_back(l); exp_t.push_back(t);
  endtask

  logic [6:0] mon_v = 0;
  int mon_l = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_sel != mon_v) begin
        if (mon_v != 0) begin
          if (exp_v.size() == 0) check(0, "R2 unexpected segment", int'(mon_v), 0);
          else begin
            int ev, el; string et;
            ev = exp_v.pop_front(); el = exp_l.pop_front(); et = exp_t.pop_front();
            check(int'(mon_v) == ev, {et, " phase"}, int'(mon_v), ev);
            check(mon_l == el, {et, " length"}, mon_l, el);
          end
        end
        mon_v = phase_sel; mon_l = 1;
      end else mon_l++;
    end
  end

  task automatic write_cfg(input logic [3:0] rd, input logic p2p, input logic [7:0] tmo,
                           input logic emu, input logic [15:0] el, input logic pau, input logic [15:0] pl);
    cfg_rd_en = rd; cfg_p2p_en = p2p; cfg_p2p_tmo = tmo;
    cfg_emu_en = emu; cfg_emu_len = el; cfg_pause_en = pau; cfg_pause_len = pl;
    cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    host_start = 1; @(negedge clk); host_start = 0;
  endtask

  task automatic wait_nth(input logic [6:0] v, input int n);
    logic [6:0] prev; int c;
    prev = phase_sel; c = 0;
    while (c < n) begin
      @(negedge clk);
      if (phase_sel == v && prev != v) c++;
      prev = phase_sel;
    end
  endtask

  task automatic hit(input int k);
    repeat (k) @(negedge clk);
    detect = 1; @(negedge clk); detect = 0;
  endtask

  task automatic idle_watch(input string tag);
    bit ok; ok = 1;
    repeat (40) begin @(negedge clk); if (phase_sel != 0 || busy) ok = 0; end
    check(ok, tag, int'(phase_sel), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(phase_sel == 0, "R1 phase_sel", int'(phase_sel), 0);
    check(busy == 0, "R1 busy", int'(busy), 0);
    check(detected == 0 && det_tech == 0, "R1 detected", int'(detected), 0);
    rst_n = 1; @(negedge clk);

    // Full loop, all phases: R2 R3 R4 R5, then detect in B of round two (R7)
    write_cfg(4'b1111, 1, 8'd2, 1, 16'd3, 1, 16'd2);
    push(PA, 12, "R3 A"); push(PB, 16, "R3 B"); push(PF2, 20, "R3 F212");
    push(PF4, 24, "R3 F424"); push(PP2, 24, "R5 p2p"); push(PEM, 24, "R4 emu");
    push(PPA, 16, "R4 pause"); push(PA, 12, "R10 repeat A"); push(PB, 6, "R7 cut B");
    pulse_start();
    wait_nth(PB, 2); hit(5);
    check(detected == 1 && !busy, "R7 detected", int'(detected), 1);
    check(det_tech == 3'd1, "R7 det_tech", int'(det_tech), 1);
    check(phase_sel == 0, "R7 stopped", int'(phase_sel), 0);

    // Degenerate modes (R6), host_start clears detected (R9)
    write_cfg(4'b0000, 0, 8'd0, 1, 16'd2, 0, 16'd0);
    pulse_start();
    check(detected == 0, "R9 clear on start", int'(detected), 0);
    idle_watch("R6 emulation only");
    write_cfg(4'b0000, 0, 8'd0, 0, 16'd0, 1, 16'd2);
    pulse_start(); idle_watch("R6 pause only");
    write_cfg(4'b0000, 0, 8'd0, 0, 16'd0, 0, 16'd0);
    pulse_start(); idle_watch("R6 all zero");
    idle_watch("R9 no self restart");

    // Pause ignores detect (R8), busy start ignored (R9), config at boundary (R10)
    write_cfg(4'b0001, 0, 8'd0, 0, 16'd0, 1, 16'd1);
    push(PA, 12, "R8 A"); push(PPA, 8, "R8 pause full"); push(PA, 12, "R9 A not restarted");
    push(PPA, 8, "R10 old pause kept"); push(PB, 1, "R10 new B");
    pulse_start();
    wait_nth(PPA, 1); hit(0);
    wait_nth(PA, 1); pulse_start();
    write_cfg(4'b0010, 0, 8'd0, 0, 16'd0, 1, 16'd1);
    wait_nth(PB, 1); hit(0);
    check(det_tech == 3'd1, "R10 det_tech", int'(det_tech), 1);

    // Zero-length emu skipped (R4), initiator after F424 (R5), detect in initiator (R7)
    write_cfg(4'b1000, 1, 8'd1, 1, 16'd0, 1, 16'd1);
    push(PF4, 24, "R2 F424"); push(PP2, 12, "R5 p2p"); push(PPA, 8, "R4 emu skipped");
    push(PF4, 24, "R2 wrap"); push(PP2, 4, "R7 cut p2p");
    pulse_start();
    wait_nth(PP2, 2); hit(3);
    check(det_tech == 3'd4, "R7 det_tech p2p", int'(det_tech), 4);
    check(detected == 1, "R7 detected p2p", int'(detected), 1);

    repeat (3) @(negedge clk);
    check(exp_v.size() == 0, "R2 scoreboard drained", exp_v.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule